// File: doc/BRIEF.md
# Activity Trace Log Buffer

This block sits beside a piece of traced logic and captures one 64-bit activity record per cycle without stalling ordinary traffic. Records go into a small on-chip queue and are packed, four at a time, into 256-bit line writes. Each line write goes to the next line of a log region in ordinary memory, which is reserved away from the running program. The lines travel over the data cache port, and a write is started only in a cycle where that port reports itself idle. The size of the log therefore follows the size of the reserved region, not the on-chip storage.

The region is given by a base address and an exclusive limit address. Line addresses rise by one line (32 bytes) for each accepted write. Once the next line would reach the limit, no further writes start and a full flag is raised. If the queue fills while the port stays busy, a stall output asks the traced logic to hold off, and records offered anyway are dropped and counted. A flush pulse pushes out a trailing partial line. The unused slots of that line are filled with an all-ones marker that means "no record".

Top module: `trace_log_buffer`

## Requirements
- R1: While reset is applied and in the first cycle after it, wr_valid is 0, rec_stall is 0 and drop_count is 0. region_full is 1 only if cfg_base is at or above cfg_limit.
- R2: A record offered with rec_valid is stored when fewer than 16 records are held. rec_stall is 1 exactly in the cycles where 16 records are held.
- R3: A line holds four records, oldest first. The oldest record is in wr_data bits [63:0], the next in [127:64], then [191:128], and the newest in [255:192].
- R4: A line write starts only if port_idle was 1 in the cycle before wr_valid rises. It also needs at least four records held, or a pending flush with at least one record held, and region_full low.
- R5: While wr_valid is 1 and wr_ready is 0, wr_valid, wr_addr and wr_data stay unchanged, whatever port_idle does.
- R6: The first line goes to cfg_base. Each accepted write (wr_valid and wr_ready both 1) moves the next line address up by 32.
- R7: region_full is 1 when the next line address is at or above cfg_limit. While it is 1, no new line write starts and the held records stay in the queue.
- R8: Each cycle where rec_valid is 1 and rec_stall is 1 adds one to drop_count, which saturates at its maximum. The dropped record is lost.
- R9: A flush pulse writes out all records held at that time, as full lines and then one last partial line. The slots of the partial line that have no record are filled with all ones. A flush with an empty queue writes nothing.
- R10: At most one line write is outstanding. After a write is accepted, wr_valid is 0 for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rec_valid | input | 1 | An activity record is offered this cycle |
| rec_data | input | 64 | Activity record |
| rec_stall | output | 1 | Queue full; the traced logic may hold off |
| flush | input | 1 | Pulse: write out any trailing partial line |
| cfg_base | input | 32 | First line address of the log region |
| cfg_limit | input | 32 | Exclusive end address of the log region |
| port_idle | input | 1 | The data cache port has no other request this cycle |
| wr_valid | output | 1 | Line write request |
| wr_ready | input | 1 | Line write accepted this cycle |
| wr_addr | output | 32 | Line address |
| wr_data | output | 256 | Four packed records |
| region_full | output | 1 | The log region has no room left |
| drop_count | output | 16 | Number of records dropped, saturating |

## Verification
A wrong queue pointer or count shows up in the first line written after it goes wrong. The result is a wrong record in a wrong slot, or a stall edge that comes one record early or late. A fault in the line cursor shows up in the address of the very next write, or as a full flag that rises while writes still go out. The bench compares every output with a behavioural model on every clock, so any such fault is reported in the cycle where it first reaches a port.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned REC_W_DEF     = 64;
    localparam int unsigned DEPTH_DEF     = 16;
    localparam int unsigned PER_LINE_DEF  = 4;
    localparam int unsigned ADDR_W_DEF    = 32;
    localparam int unsigned DROP_W_DEF    = 16;
endpackage

// File: rtl/tlb_fifo.sv
module tlb_fifo #(
    parameter int unsigned W     = 64,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned PEEK  = 4,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PN_W  = $clog2(PEEK + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_i,
    input  logic [W-1:0]        push_data_i,
    input  logic [PN_W-1:0]     pop_n_i,
    output logic [PEEK*W-1:0]   peek_o,
    output logic [CNT_W-1:0]    count_o
);
    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        s_d     = s_q;
        s_d.rd  = s_q.rd + PTR_W'(pop_n_i);
        s_d.cnt = s_q.cnt + CNT_W'(push_i) - CNT_W'(pop_n_i);
        if (push_i) begin
            s_d.wr = s_q.wr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_q[s_q.wr] <= push_data_i;
        end
    end

    for (genvar i = 0; i < PEEK; i++) begin : g_peek
        assign peek_o[i*W +: W] = mem_q[s_q.rd + PTR_W'(i)];
    end

    assign count_o = s_q.cnt;
endmodule

// File: rtl/tlb_cursor.sv
module tlb_cursor #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 32,
    localparam int unsigned SHIFT     = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base_i,
    input  logic [ADDR_W-1:0] cfg_limit_i,
    input  logic              advance_i,
    output logic [ADDR_W-1:0] line_addr_o,
    output logic              region_full_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] lines;
    } cur_st_t;

    cur_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (advance_i) begin
            s_d.lines = s_q.lines + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_addr_o   = cfg_base_i + (s_q.lines << SHIFT);
    assign region_full_o = (line_addr_o >= cfg_limit_i);
endmodule

// File: rtl/tlb_issue.sv
module tlb_issue #(
    parameter int unsigned W        = 64,
    parameter int unsigned PER_LINE = 4,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned CNT_W    = 5,
    parameter logic [W-1:0] PAD     = '1,
    localparam int unsigned LINE_W  = W * PER_LINE,
    localparam int unsigned PN_W    = $clog2(PER_LINE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [LINE_W-1:0] peek_i,
    input  logic              port_idle_i,
    input  logic              region_full_i,
    input  logic              flush_i,
    input  logic              wr_ready_i,
    input  logic [ADDR_W-1:0] line_addr_i,
    output logic [PN_W-1:0]   pop_n_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [LINE_W-1:0] wr_data_o,
    output logic              advance_o
);
    typedef struct packed {
        logic              valid;
        logic              flush_pend;
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] data;
    } iss_st_t;

    iss_st_t s_d, s_q;
    logic            whole;
    logic            launch;
    logic            clear;
    logic            accept;
    logic [PN_W-1:0] take;

    always_comb begin
        whole  = (count_i >= CNT_W'(PER_LINE));
        take   = whole ? PN_W'(PER_LINE) : PN_W'(count_i);
        launch = !s_q.valid && port_idle_i && !region_full_i &&
                 (whole || (s_q.flush_pend && (count_i != '0)));
        clear  = s_q.flush_pend &&
                 ((count_i == '0) || (launch && (count_i <= CNT_W'(PER_LINE))));
        accept = s_q.valid && wr_ready_i;

        s_d = s_q;
        if (accept) begin
            s_d.valid = 1'b0;
        end
        if (launch) begin
            s_d.valid = 1'b1;
            s_d.addr  = line_addr_i;
            for (int i = 0; i < PER_LINE; i++) begin
                s_d.data[i*W +: W] = (PN_W'(i) < take) ? peek_i[i*W +: W] : PAD;
            end
        end
        s_d.flush_pend = flush_i | (s_q.flush_pend & !clear);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pop_n_o    = launch ? take : '0;
    assign wr_valid_o = s_q.valid;
    assign wr_addr_o  = s_q.addr;
    assign wr_data_o  = s_q.data;
    assign advance_o  = accept;
endmodule

// File: rtl/trace_log_buffer.sv
module trace_log_buffer #(
    parameter int unsigned REC_W      = tlb_pkg::REC_W_DEF,
    parameter int unsigned FIFO_DEPTH = tlb_pkg::DEPTH_DEF,
    parameter int unsigned PER_LINE   = tlb_pkg::PER_LINE_DEF,
    parameter int unsigned ADDR_W     = tlb_pkg::ADDR_W_DEF,
    parameter int unsigned DROP_W     = tlb_pkg::DROP_W_DEF,
    parameter logic [REC_W-1:0] PAD_REC = '1,
    localparam int unsigned LINE_W     = REC_W * PER_LINE,
    localparam int unsigned LINE_BYTES = LINE_W / 8,
    localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1),
    localparam int unsigned PN_W       = $clog2(PER_LINE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  logic [REC_W-1:0]  rec_data,
    output logic              rec_stall,
    input  logic              flush,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic              port_idle,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LINE_W-1:0] wr_data,
    output logic              region_full,
    output logic [DROP_W-1:0] drop_count
);
    typedef struct packed {
        logic [DROP_W-1:0] drops;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [CNT_W-1:0]  held;
    logic [LINE_W-1:0] peek;
    logic [PN_W-1:0]   pop_n;
    logic              push;
    logic              advance;
    logic [ADDR_W-1:0] line_addr;

    assign rec_stall = (held == CNT_W'(FIFO_DEPTH));
    assign push      = rec_valid && !rec_stall;

    always_comb begin
        s_d = s_q;
        if (rec_valid && rec_stall && (s_q.drops != '1)) begin
            s_d.drops = s_q.drops + DROP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign drop_count = s_q.drops;

    tlb_fifo #(
        .W     (REC_W),
        .DEPTH (FIFO_DEPTH),
        .PEEK  (PER_LINE)
    ) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i (rec_data),
        .pop_n_i     (pop_n),
        .peek_o      (peek),
        .count_o     (held)
    );

    tlb_cursor #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_cursor (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_base_i    (cfg_base),
        .cfg_limit_i   (cfg_limit),
        .advance_i     (advance),
        .line_addr_o   (line_addr),
        .region_full_o (region_full)
    );

    tlb_issue #(
        .W        (REC_W),
        .PER_LINE (PER_LINE),
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .PAD      (PAD_REC)
    ) u_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .count_i       (held),
        .peek_i        (peek),
        .port_idle_i   (port_idle),
        .region_full_i (region_full),
        .flush_i       (flush),
        .wr_ready_i    (wr_ready),
        .line_addr_i   (line_addr),
        .pop_n_o       (pop_n),
        .wr_valid_o    (wr_valid),
        .wr_addr_o     (wr_addr),
        .wr_data_o     (wr_data),
        .advance_o     (advance)
    );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LINE_W = 256,
    parameter int unsigned DROP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rec_valid,
    input logic              rec_stall,
    input logic              port_idle,
    input logic              region_full,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [LINE_W-1:0] wr_data,
    input logic [DROP_W-1:0] drop_count
);
    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R5

    AST_START_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(port_idle)); // R4

    AST_NO_START_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> !$past(region_full)); // R7

    AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready |=> !wr_valid); // R10

    AST_DROP_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> $past(rec_valid && rec_stall)); // R8
endmodule

bind trace_log_buffer tlb_checker #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .DROP_W (DROP_W)
) u_tlb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rec_valid   (rec_valid),
    .rec_stall   (rec_stall),
    .port_idle   (port_idle),
    .region_full (region_full),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .drop_count  (drop_count)
);

// File: tb/sim_trace_log_buffer.sv
module sim_trace_log_buffer;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE  = 32'h0000_1000;
    localparam logic [31:0] LIMIT = 32'h0000_1000 + 32'd7 * 32'd32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rec_valid = 1'b0;
    logic [63:0]  rec_data = '0;
    logic         rec_stall;
    logic         flush = 1'b0;
    logic [31:0]  cfg_base = BASE;
    logic [31:0]  cfg_limit = LIMIT;
    logic         port_idle = 1'b0;
    logic         wr_valid;
    logic         wr_ready = 1'b0;
    logic [31:0]  wr_addr;
    logic [255:0] wr_data;
    logic         region_full;
    logic [15:0]  drop_count;

    int checks = 0;
    int fails  = 0;
    int rec_no = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_log_buffer u0 (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_data(rec_data),
        .rec_stall(rec_stall), .flush(flush), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .port_idle(port_idle), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .region_full(region_full), .drop_count(drop_count)
    );

    // behavioural reference
    logic [63:0]  mq[$];
    logic         m_valid;
    logic [31:0]  m_addr;
    logic [255:0] m_data;
    int           m_lines;
    logic         m_flush;
    int           m_drops;

    function automatic logic [31:0] m_next_addr();
        return BASE + 32'(m_lines * 32);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_valid = 1'b0; m_addr = '0; m_data = '0;
            m_lines = 0; m_flush = 1'b0; m_drops = 0;
        end else begin
            int  sz;
            bit  full_rgn, launch, clear, accept, stalled;
            sz       = mq.size();
            full_rgn = (m_next_addr() >= LIMIT);
            stalled  = (sz == 16);
            launch   = !m_valid && port_idle && !full_rgn &&
                       (sz >= 4 || (m_flush && sz > 0));
            clear    = m_flush && (sz == 0 || (launch && sz <= 4));
            accept   = m_valid && wr_ready;
            if (accept) begin
                m_valid = 1'b0;
                m_lines++;
            end
            if (launch) begin
                m_valid = 1'b1;
                m_addr  = m_next_addr();
                m_data  = '1;
                for (int i = 0; i < 4; i++) begin
                    if (mq.size() > 0) m_data[i*64 +: 64] = mq.pop_front();
                end
            end
            if (rec_valid) begin
                if (!stalled) mq.push_back(rec_data);
                else if (m_drops < 65535) m_drops++;
            end
            m_flush = flush || (m_flush && !clear);
        end
    end

    task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 rec_stall", 256'(rec_stall), 256'(mq.size() == 16));
        chk("R4 R10 wr_valid", 256'(wr_valid), 256'(m_valid));
        chk("R7 region_full", 256'(region_full), 256'(m_next_addr() >= LIMIT));
        chk("R8 drop_count", 256'(drop_count), 256'(m_drops));
        if (m_valid) begin
            chk("R6 wr_addr", 256'(wr_addr), 256'(m_addr));
            chk("R3 R9 wr_data", wr_data, m_data);
        end
    endtask

    task automatic step(bit v, bit idle, bit rdy, bit fl);
        rec_valid = v;
        if (v) begin
            rec_no++;
            rec_data = {32'hC0DE_0000 | 32'(rec_no), 32'(rec_no * 7)};
        end
        port_idle = idle;
        wr_ready  = rdy;
        flush     = fl;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during reset
        chk("R1 wr_valid", 256'(wr_valid), 256'(0));
        chk("R1 rec_stall", 256'(rec_stall), 256'(0));
        chk("R1 drop_count", 256'(drop_count), 256'(0));
        chk("R1 region_full", 256'(region_full), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // R3 R4 R6: steady traffic, idle port
        for (int i = 0; i < 8; i++) step(1, 1, 1, 0);
        for (int i = 0; i < 6; i++) step(0, 1, 1, 0);

        // R9: partial line on flush, then flush with empty queue
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0);
        step(0, 1, 1, 1);
        for (int i = 0; i < 5; i++) step(0, 1, 1, 0);
        step(0, 1, 1, 1);
        for (int i = 0; i < 4; i++) step(0, 1, 1, 0);

        // R5: request held while not ready, port_idle toggling
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0);
        for (int i = 0; i < 6; i++) step(0, i % 2 == 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 1, 1, 0);

        // R2 R8: busy port fills queue, extra records dropped
        for (int i = 0; i < 22; i++) step(1, 0, 1, 0);
        // R7: drain until region full, remainder stays held
        for (int i = 0; i < 20; i++) step(0, 1, 1, 0);
        for (int i = 0; i < 14; i++) step(1, 1, 1, 0);
        for (int i = 0; i < 4; i++) step(0, 1, 1, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule